// File: doc/BRIEF.md
# Nibble-Select Pixel Unpacker

This block is the pixel input stage of a video palette. It accepts a 32-bit pixel port arranged as four bytes and turns each loaded word into a stream of 4-bit palette indices, one per pixel clock, with a valid strobe alongside. Nibble mode is active when the nibble-enable mode bit is set and the split-transfer mode bit is clear. In that mode one nibble is taken from each byte to form a 16-bit word. An external select flag decides whether the upper or the lower nibble of each byte is used. In every other mode the low 16 bits of the port are used unchanged.

The select flag has a second role. When split-transfer mode is enabled, a rising edge on the flag requests one extra shift-clock pulse. This request does not depend on blanking. While the flag stays low, the shift-clock request behaves as it does with split transfer disabled: one pulse after the fourth pixel of each word, asking the frame buffer for the next load. Blanking clears the pixel stream.

Top module: `nibble_unpacker`

## Requirements
- R1: Nibble mode is active only when `cfg_nib_en` is 1 and `cfg_split_en` is 0. Any other combination selects plain mode.
- R2: In nibble mode with `sel_flag` = 1 at the load, the four pixels are bits 7..4, 15..12, 23..20 and 31..28 of `pix_word`, in that order.
- R3: In nibble mode with `sel_flag` = 0 at the load, the four pixels are bits 3..0, 11..8, 19..16 and 27..24 of `pix_word`, in that order.
- R4: The nibble selection uses the value of `sel_flag` in the load cycle. Later changes of the flag do not alter pixels already loaded.
- R5: A load with `blank` low puts the first pixel on `pix_out` with `pix_valid` high on the next clock. The remaining three pixels follow on the three clocks after that. Whenever `pix_valid` is low, `pix_out` is 0.
- R6: `shift_req` is high for exactly one cycle, in the cycle after the fourth pixel is shown, provided `blank` is low in the cycle where the fourth pixel is shown.
- R7: With `blank` high, the next cycle shows `pix_valid` = 0 and `pix_out` = 0. Any pixels not yet shown are discarded.
- R8: With `cfg_split_en` = 1, a 0-to-1 change of `sel_flag` gives a one-cycle `shift_req` pulse on the following cycle, whatever the level of `blank`. A flag held high gives no further pulses.
- R9: With `cfg_split_en` = 1 and `sel_flag` held low, `shift_req` follows only the end-of-word rule of R6.
- R10: A load while pixels are still pending discards the old word and restarts the sequence with the new word.
- R11: While `rst_n` is low, `pix_out`, `pix_valid` and `shift_req` are 0. Internal state leaves reset on the second clock after `rst_n` rises.
- R12: In plain mode the four pixels are bits 3..0, 7..4, 11..8 and 15..12 of `pix_word`, and `sel_flag` has no effect on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_nib_en | input | 1 | Mode bit requesting nibble mode |
| cfg_split_en | input | 1 | Mode bit enabling split-transfer shift pulses |
| sel_flag | input | 1 | Nibble select in nibble mode; split-transfer gate in split mode |
| blank | input | 1 | Blanking, active high |
| load | input | 1 | Load strobe for `pix_word` |
| pix_word | input | 32 | Pixel port, four bytes |
| pix_out | output | 4 | Pixel index toward the palette |
| pix_valid | output | 1 | `pix_out` holds a pixel |
| shift_req | output | 1 | Shift-clock request pulse |

## Verification
The bench builds the block with its default parameters: 4-bit nibbles and four byte lanes, which gives the 32-bit port and the 16-bit nibble word. With these values, every corner of the lane multiplexer is reached. This covers both nibble halves, plain mode, and the case where split mode blocks nibble mode. It also reaches the last-lane wrap of the counter, where the end-of-word pulse is generated. A behavioural queue model predicts every output on every clock. The stimulus includes the following cases:
- blanking that falls mid-word and on the tail pixel;
- reloads while pixels are pending;
- flag changes after a load;
- split-transfer pulses raised during blanking.

// File: rtl/nup_pkg.sv
package nup_pkg;
  typedef enum logic [1:0] {
    SEL_PLAIN = 2'd0,
    SEL_LOW   = 2'd1,
    SEL_HIGH  = 2'd2
  } sel_mode_e;
endpackage

// File: rtl/nup_rst_sync.sv
module nup_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_q_n = hold_q;
endmodule

// File: rtl/nup_lane_select.sv
module nup_lane_select
  import nup_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int LANES = 4,
  localparam int BYTE_W = 2 * NIB_W,
  localparam int PORT_W = LANES * BYTE_W,
  localparam int WORD_W = LANES * NIB_W
) (
  input  logic [PORT_W-1:0] port_in,
  input  sel_mode_e         mode,
  output logic [WORD_W-1:0] word_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [NIB_W-1:0] upper_nib;
    logic [NIB_W-1:0] lower_nib;
    logic [NIB_W-1:0] plain_nib;

    // Upper and lower halves of byte g; plain mode reads the packed low word.
    assign upper_nib = port_in[g*BYTE_W + NIB_W +: NIB_W];
    assign lower_nib = port_in[g*BYTE_W +: NIB_W];
    assign plain_nib = port_in[g*NIB_W +: NIB_W];

    assign word_out[g*NIB_W +: NIB_W] =
        (mode == SEL_HIGH) ? upper_nib :
        (mode == SEL_LOW)  ? lower_nib : plain_nib;
  end
endmodule

// File: rtl/nup_serializer.sv
module nup_serializer #(
  parameter int NIB_W = 4,
  parameter int LANES = 4,
  localparam int WORD_W = LANES * NIB_W,
  localparam int CNT_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blank,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  output logic [NIB_W-1:0]  pix,
  output logic              vld,
  output logic [CNT_W-1:0]  idx
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'((LANES > 1) ? 1 : 0);

  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic [NIB_W-1:0]  pix_q, pix_d;
  logic              vld_q, vld_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic              upd_en;

  // The registers only move while there is something to do.
  assign upd_en = blank | load | busy_q | vld_q;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    pix_d  = pix_q;
    vld_d  = vld_q;
    idx_d  = idx_q;
    if (blank) begin
      cnt_d  = '0;
      busy_d = 1'b0;
      pix_d  = '0;
      vld_d  = 1'b0;
      idx_d  = '0;
    end else if (load) begin
      word_d = word_in;
      pix_d  = word_in[NIB_W-1:0];
      vld_d  = 1'b1;
      idx_d  = '0;
      cnt_d  = ONE;
      busy_d = (LANES > 1);
    end else if (busy_q) begin
      pix_d  = word_q[int'(cnt_q)*NIB_W +: NIB_W];
      vld_d  = 1'b1;
      idx_d  = cnt_q;
      busy_d = (cnt_q != LAST);
      cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
    end else begin
      pix_d  = '0;
      vld_d  = 1'b0;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      pix_q  <= '0;
      vld_q  <= 1'b0;
      idx_q  <= '0;
    end else if (upd_en) begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      pix_q  <= pix_d;
      vld_q  <= vld_d;
      idx_q  <= idx_d;
    end
  end

  assign pix = pix_q;
  assign vld = vld_q;
  assign idx = idx_q;
endmodule

// File: rtl/nup_shift_ctl.sv
module nup_shift_ctl #(
  parameter int LANES = 4,
  localparam int CNT_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             split_en,
  input  logic             flag,
  input  logic             blank,
  input  logic             vld,
  input  logic [CNT_W-1:0] idx,
  output logic             shift_req
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);

  logic flag_q, flag_d;
  logic shift_q, shift_d;
  logic tail_req;
  logic split_req;

  // End of word: the last lane is on the output and the line is not blanked.
  assign tail_req  = vld & (idx == LAST) & ~blank;
  // Split transfer: the flag rises; blanking is deliberately ignored.
  assign split_req = split_en & flag & ~flag_q;

  always_comb begin
    flag_d  = flag;
    shift_d = tail_req | split_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      shift_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      shift_q <= shift_d;
    end
  end

  assign shift_req = shift_q;
endmodule

// File: rtl/nibble_unpacker.sv
module nibble_unpacker
  import nup_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int LANES = 4,
  localparam int PORT_W = LANES * 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_nib_en,
  input  logic              cfg_split_en,
  input  logic              sel_flag,
  input  logic              blank,
  input  logic              load,
  input  logic [PORT_W-1:0] pix_word,
  output logic [NIB_W-1:0]  pix_out,
  output logic              pix_valid,
  output logic              shift_req
);
  localparam int WORD_W = LANES * NIB_W;
  localparam int CNT_W  = (LANES > 1) ? $clog2(LANES) : 1;

  logic              rst_q_n;
  logic              nib_active;
  sel_mode_e         sel_mode;
  logic [WORD_W-1:0] packed_word;
  logic [CNT_W-1:0]  shown_idx;

  // Split transfer takes precedence over nibble mode.
  assign nib_active = cfg_nib_en & ~cfg_split_en;
  assign sel_mode   = !nib_active ? SEL_PLAIN :
                      (sel_flag ? SEL_HIGH : SEL_LOW);

  nup_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  nup_lane_select #(.NIB_W(NIB_W), .LANES(LANES)) u_sel (
    .port_in  (pix_word),
    .mode     (sel_mode),
    .word_out (packed_word)
  );

  nup_serializer #(.NIB_W(NIB_W), .LANES(LANES)) u_ser (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .blank   (blank),
    .load    (load),
    .word_in (packed_word),
    .pix     (pix_out),
    .vld     (pix_valid),
    .idx     (shown_idx)
  );

  nup_shift_ctl #(.LANES(LANES)) u_shift (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .split_en  (cfg_split_en),
    .flag      (sel_flag),
    .blank     (blank),
    .vld       (pix_valid),
    .idx       (shown_idx),
    .shift_req (shift_req)
  );
endmodule

// File: rtl/nibble_unpacker_chk.sv
module nibble_unpacker_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             cfg_split_en,
  input logic             sel_flag,
  input logic             blank,
  input logic [NIB_W-1:0] pix_out,
  input logic             pix_valid,
  input logic             shift_req
);
  // R5: an idle output carries zero
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    !pix_valid |-> pix_out == '0);

  // R7: blanking empties the stream on the next cycle
  a_r7_blank_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    blank |=> (!pix_valid && pix_out == '0));

  // R8: a rising flag in split mode produces a pulse
  a_r8_split_pulse: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cfg_split_en && $rose(sel_flag)) |=> shift_req);

  // R9: without split mode, a pulse needs a shown pixel outside blanking
  a_r9_plain_shift: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!$past(cfg_split_en) && shift_req) |-> ($past(pix_valid) && !$past(blank)));
endmodule

bind nibble_unpacker nibble_unpacker_chk #(.NIB_W(NIB_W)) u_chk (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .cfg_split_en (cfg_split_en),
  .sel_flag     (sel_flag),
  .blank        (blank),
  .pix_out      (pix_out),
  .pix_valid    (pix_valid),
  .shift_req    (shift_req)
);

// File: tb/nibble_unpacker_test.sv
`timescale 1ns/1ps
module nibble_unpacker_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_nib_en, cfg_split_en, sel_flag, blank, load;
  logic [31:0] pix_word;
  logic [3:0]  pix_out;
  logic        pix_valid, shift_req;

  int    n_vec  = 0;
  int    n_bad  = 0;
  bit    comparing = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R11";

  always #5 clk = ~clk;

  nibble_unpacker uut (
    .clk(clk), .rst_n(rst_n), .cfg_nib_en(cfg_nib_en), .cfg_split_en(cfg_split_en),
    .sel_flag(sel_flag), .blank(blank), .load(load), .pix_word(pix_word),
    .pix_out(pix_out), .pix_valid(pix_valid), .shift_req(shift_req)
  );

  // Behavioural reference: a queue of pending pixels per the requirements.
  logic [3:0] q[$];
  logic [3:0] m_pix;
  logic       m_vld, m_shift, m_last, m_fq, m_s1, m_s2;

  function automatic logic [3:0] pick(input logic [31:0] w, input int k,
                                      input logic nib, input logic spl, input logic f);
    if (nib && !spl) return f ? w[8*k+4 +: 4] : w[8*k +: 4];
    return w[4*k +: 4];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_pix = 0; m_vld = 0; m_shift = 0; m_last = 0; m_fq = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      if (m_s2) begin
        logic prev_last;
        prev_last = m_last;
        m_shift = (prev_last && !blank) || (cfg_split_en && sel_flag && !m_fq);
        m_fq = sel_flag;
        if (blank) begin
          q.delete(); m_pix = 0; m_vld = 0; m_last = 0;
        end else if (load) begin
          q.delete();
          for (int k = 0; k < 4; k++) q.push_back(pick(pix_word, k, cfg_nib_en, cfg_split_en, sel_flag));
          m_pix = q.pop_front(); m_vld = 1; m_last = 0;
        end else if (q.size() > 0) begin
          m_pix = q.pop_front(); m_vld = 1; m_last = (q.size() == 0);
        end else begin
          m_pix = 0; m_vld = 0; m_last = 0;
        end
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
  end

  always @(negedge clk) begin
    if (comparing && !done) begin
      n_vec++;
      if (pix_out !== m_pix || pix_valid !== m_vld || shift_req !== m_shift) begin
        n_bad++;
        $display("FAIL %s: pix=%h vld=%b shift=%b expected pix=%h vld=%b shift=%b",
                 cur_req, pix_out, pix_valid, shift_req, m_pix, m_vld, m_shift);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_load(input logic [31:0] w);
    load = 1; pix_word = w; tick(1); load = 0;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_nib_en = 0; cfg_split_en = 0; sel_flag = 0;
    blank = 0; load = 0; pix_word = 0;
    tick(4);
    // R11: reset state at the ports
    n_vec++;
    if (pix_out !== 0 || pix_valid !== 0 || shift_req !== 0) begin
      n_bad++;
      $display("FAIL R11: pix=%h vld=%b shift=%b expected 0 0 0", pix_out, pix_valid, shift_req);
    end
    comparing = 1'b1;
    rst_n = 1; tick(4);

    cur_req = "R3"; cfg_nib_en = 1; sel_flag = 0;
    do_load(32'hA5C3_96F1); tick(6);
    cur_req = "R2"; sel_flag = 1;
    do_load(32'hA5C3_96F1); tick(6);
    cur_req = "R4"; sel_flag = 1;
    do_load(32'h1234_5678); sel_flag = 0; tick(2); sel_flag = 1; tick(4);
    cur_req = "R12"; cfg_nib_en = 0;
    do_load(32'hFFFF_BEEF); sel_flag = 0; tick(5);
    do_load(32'h0000_C0DE); tick(5);
    cur_req = "R1"; cfg_nib_en = 1; cfg_split_en = 1; sel_flag = 0;
    do_load(32'h9876_4321); tick(6);
    cfg_split_en = 0;
    cur_req = "R5";
    for (int i = 0; i < 4; i++) begin
      sel_flag = i[0];
      do_load(32'h0F1E_2D3C + 32'(i) * 32'h1111_1111); tick(3);
    end
    tick(3);
    cur_req = "R10";
    do_load(32'hAAAA_AAAA); tick(1); do_load(32'h5555_1234); tick(6);
    cur_req = "R7";
    do_load(32'h7654_3210); tick(1); blank = 1; tick(2); blank = 0; tick(4);
    cur_req = "R6";
    do_load(32'hCAFE_F00D); tick(2); blank = 1; tick(2); blank = 0; tick(3);
    do_load(32'h1357_9BDF); tick(6);
    cur_req = "R8"; cfg_split_en = 1; sel_flag = 0; blank = 1; tick(2);
    sel_flag = 1; tick(4); sel_flag = 0; tick(2); sel_flag = 1; blank = 0; tick(3);
    sel_flag = 0; tick(2);
    cur_req = "R9";
    do_load(32'h2468_ACE0); tick(6);
    do_load(32'hDEAD_BEEF); tick(2); blank = 1; tick(1); blank = 0; tick(4);
    cfg_split_en = 0; cfg_nib_en = 0;
    cur_req = "R11"; rst_n = 0; tick(3); rst_n = 1; load = 1; pix_word = 32'h1111_2222;
    tick(4); load = 0; tick(6);
    finish_run();
  end
endmodule